// File: doc/BRIEF.md
# Make-Before-Break Wiper Tap Selector

This block turns the value held in a wiper position register into the enable lines for the switches of a resistor tap array. In steady state exactly one switch is closed. When a new position is loaded, the switch for the new tap closes first and stays closed together with the old one for a set number of clock cycles. Only after that does the old switch open, so the wiper output is never left floating.

Codes above the top tap saturate at the top tap. They never wrap around to tap 0. Any jump between two taps is allowed, whatever bits differ between the two codes. A load that arrives during an overlap is held and applied once that overlap ends. The same block serves a 256-tap channel, where each code maps straight to its tap, and a 100-tap channel. The `NUM_TAPS` parameter selects which.

Top module: `wiper_tap_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, only bit 0 of `tap_en_o` is set and `busy_o` is low.
- R2: While `busy_o` is low, exactly one bit of `tap_en_o` is set.
- R3: A load at clock edge k whose clamped code differs from the current tap behaves as follows. From edge k on, `tap_en_o` has both the old and the new tap bits set and `busy_o` is high, for `OVERLAP_CYC` cycles. After that, only the new tap bit is set.
- R4: `tap_en_o` never has zero bits set. A bit clears only at the end of an overlap. A new bit sets only while `busy_o` is high.
- R5: A code greater than `NUM_TAPS-1` selects tap `NUM_TAPS-1`, which is bit `NUM_TAPS-1` of `tap_en_o`.
- R6: A code of at most `NUM_TAPS-1` selects the tap whose index equals the code. For example, code 15 sets bit 15.
- R7: Any tap can be reached from any other tap in a single transition, whatever the number of bits that differ between the two codes.
- R8: A load while idle whose clamped code equals the current tap leaves `tap_en_o` unchanged and keeps `busy_o` low.
- R9: A load that arrives while `busy_o` is high is held. One cycle after the overlap ends, a new overlap toward the held tap begins. A later held load replaces an earlier one.
- R10: While `load_i` is low, `code_i` has no effect on `tap_en_o` or `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Strobe: take `code_i` as the new wiper position |
| code_i | input | CODE_W | Requested wiper position code |
| tap_en_o | output | NUM_TAPS | One enable per tap switch |
| busy_o | output | 1 | High during the make-before-break overlap |

## Verification
Several rules are checked by assertions on every cycle:
- the count of enabled taps, one when idle and two during an overlap;
- the make-before-break order of setting and clearing bits;
- the bound on overlap length;
- saturation of codes above the top tap;
- the hold of a load that arrives while busy.

Other behaviour is shown only by the bench, which compares both a 256-tap and a 100-tap instance against a cycle model under mixed random and directed loads:
- that the right tap is reached;
- that a held load is applied one cycle after the overlap ends and that a later one overrides it;
- that `code_i` is ignored while `load_i` is low.

// File: rtl/wiper_pkg.sv
// Package: shared types for the wiper tap selector.
// Assumes: nothing beyond the two-phase sequencing it names.
package wiper_pkg;

    // Sequencer phase: steady single tap, or two taps overlapping.
    typedef enum logic {
        ST_HOLD    = 1'b0,
        ST_OVERLAP = 1'b1
    } wstate_e;

endpackage

// File: rtl/tap_clamp.sv
// Module: tap_clamp
// Maps a requested code to a tap index. Codes above the top tap saturate
// at the top tap instead of wrapping.
// Assumes: IDX_W is wide enough to hold NUM_TAPS-1.
module tap_clamp #(
    parameter int NUM_TAPS = 256,
    parameter int CODE_W   = 8,
    parameter int IDX_W    = 8
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int              TOP_INT  = NUM_TAPS - 1;
    localparam logic [CODE_W:0] TOP_CODE = (CODE_W+1)'(TOP_INT);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOP_INT);

    // Saturating conversion from code to index.
    always_comb begin
        if ({1'b0, code_i} > TOP_CODE) begin
            idx_o = TOP_IDX;
        end else begin
            idx_o = IDX_W'(code_i);
        end
    end
endmodule

// File: rtl/tap_decode.sv
// Module: tap_decode
// Decodes a tap index into a one-hot vector, gated by an enable input.
// Assumes: the index is never above NUM_TAPS-1 (the clamp guarantees this).
module tap_decode #(
    parameter int NUM_TAPS = 256,
    parameter int IDX_W    = 8
) (
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                en_i,
    output logic [NUM_TAPS-1:0] onehot_o
);
    // One comparator per tap switch.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign onehot_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/tap_seq.sv
// Module: tap_seq
// Make-before-break sequencer. It holds the current tap. On a new target
// it enters an overlap of OVERLAP_CYC cycles, then hands over to the
// target. A load during the overlap is held and applied after it.
// Assumes: OVERLAP_CYC >= 1; req_idx_i has already been clamped.
module tap_seq
    import wiper_pkg::*;
#(
    parameter int NUM_TAPS    = 256,
    parameter int IDX_W       = 8,
    parameter int OVERLAP_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] req_idx_i,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic [IDX_W-1:0] nxt_idx_o,
    output logic             busy_o
);
    localparam int CNT_W = (OVERLAP_CYC > 1) ? $clog2(OVERLAP_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERLAP_CYC - 1);

    wstate_e          state_q;
    logic [IDX_W-1:0] cur_q, nxt_q, pend_q;
    logic             pend_v_q;
    logic [CNT_W-1:0] cnt_q;

    logic             take_v;
    logic [IDX_W-1:0] take_idx;
    logic             start;
    logic             done;

    // Choose the target: a fresh load wins over a held one.
    always_comb begin
        take_v   = load_i || pend_v_q;
        take_idx = load_i ? req_idx_i : pend_q;
        start    = (state_q == ST_HOLD) && take_v && (take_idx != cur_q);
        done     = (state_q == ST_OVERLAP) && (cnt_q == CNT_LAST);
    end

    // Phase, tap registers, overlap counter and held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HOLD;
            cur_q    <= '0;
            nxt_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            case (state_q)
                ST_HOLD: begin
                    pend_v_q <= 1'b0;
                    if (start) begin
                        nxt_q   <= take_idx;
                        cnt_q   <= '0;
                        state_q <= ST_OVERLAP;
                    end
                end
                default: begin
                    if (load_i) begin
                        pend_q   <= req_idx_i;
                        pend_v_q <= 1'b1;
                    end
                    cnt_q <= cnt_q + 1'b1;
                    if (done) begin
                        cur_q   <= nxt_q;
                        state_q <= ST_HOLD;
                    end
                end
            endcase
        end
    end

    assign cur_idx_o = cur_q;
    assign nxt_idx_o = nxt_q;
    assign busy_o    = (state_q == ST_OVERLAP);

    // R3
    overlap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(cnt_q) < OVERLAP_CYC));

    // R5
    target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(nxt_q) <= NUM_TAPS - 1));

    // R8
    same_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && load_i && (req_idx_i == cur_q)) |=> !busy_o);

    // R9
    held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && load_i) |=> (pend_v_q && pend_q == $past(req_idx_i)));
endmodule

// File: rtl/wiper_tap_sel.sv
// Module: wiper_tap_sel (top)
// Drives tap switch enables from a wiper position code. A tap change uses
// a make-before-break order; out-of-range codes saturate at the top tap.
// Assumes: NUM_TAPS >= 2, OVERLAP_CYC >= 1, enables are active high.
module wiper_tap_sel #(
    parameter int NUM_TAPS    = 256,
    parameter int CODE_W      = 8,
    parameter int OVERLAP_CYC = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [NUM_TAPS-1:0] tap_en_o,
    output logic                busy_o
);
    localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

    logic [IDX_W-1:0]    req_idx;
    logic [IDX_W-1:0]    cur_idx;
    logic [IDX_W-1:0]    nxt_idx;
    logic                busy;
    logic [NUM_TAPS-1:0] cur_hot;
    logic [NUM_TAPS-1:0] nxt_hot;

    tap_clamp #(.NUM_TAPS(NUM_TAPS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_clamp (
        .code_i (code_i),
        .idx_o  (req_idx)
    );

    tap_seq #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W), .OVERLAP_CYC(OVERLAP_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .req_idx_i (req_idx),
        .cur_idx_o (cur_idx),
        .nxt_idx_o (nxt_idx),
        .busy_o    (busy)
    );

    tap_decode #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_dec_cur (
        .idx_i    (cur_idx),
        .en_i     (1'b1),
        .onehot_o (cur_hot)
    );

    tap_decode #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_dec_nxt (
        .idx_i    (nxt_idx),
        .en_i     (busy),
        .onehot_o (nxt_hot)
    );

    // Merge the held tap with the incoming tap during an overlap.
    always_comb begin
        tap_en_o = cur_hot | nxt_hot;
        busy_o   = busy;
    end

    // R2
    idle_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ($countones(tap_en_o) == 1));

    // R3
    overlap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones(tap_en_o) == 2));

    // R4
    break_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(tap_en_o) & ~tap_en_o)) |-> ($past(busy_o) && !busy_o));

    // R4
    make_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tap_en_o & ~$past(tap_en_o))) |-> busy_o);

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && load_i && ({1'b0, code_i} > (CODE_W+1)'(NUM_TAPS - 1)))
        |=> tap_en_o[NUM_TAPS-1]);
endmodule

// File: tb/wiper_tap_sel_tb.sv
// Cycle reference model derived from the requirements.
module wiper_ref #(
    parameter int NUM_TAPS    = 256,
    parameter int OVERLAP_CYC = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [7:0]          code_i,
    output logic [NUM_TAPS-1:0] exp_en_o,
    output logic                exp_busy_o
);
    int cur, tgt, pend, rem;
    bit busy, pv;

    function automatic int clampf(input int c);
        return (c > NUM_TAPS - 1) ? NUM_TAPS - 1 : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cur = 0; tgt = 0; pend = 0; rem = 0; busy = 0; pv = 0;
        end else if (busy) begin
            if (load_i) begin pend = clampf(int'(code_i)); pv = 1; end
            rem = rem - 1;
            if (rem == 0) begin cur = tgt; busy = 0; end
        end else begin
            int take;
            bit tv;
            tv   = load_i || pv;
            take = load_i ? clampf(int'(code_i)) : pend;
            pv   = 0;
            if (tv && take != cur) begin
                tgt = take; busy = 1; rem = OVERLAP_CYC;
            end
        end
    end

    always_comb begin
        exp_en_o = '0;
        exp_en_o[cur] = 1'b1;
        if (busy) exp_en_o[tgt] = 1'b1;
        exp_busy_o = busy;
    end
endmodule

module wiper_tap_sel_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [7:0] code = '0;
    logic [255:0] en256;
    logic [99:0]  en100;
    logic busy256, busy100;
    logic [255:0] x256;
    logic [99:0]  x100;
    logic xb256, xb100;
    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wiper_tap_sel #(.NUM_TAPS(256), .CODE_W(8), .OVERLAP_CYC(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code),
        .tap_en_o(en256), .busy_o(busy256));

    wiper_tap_sel #(.NUM_TAPS(100), .CODE_W(8), .OVERLAP_CYC(3)) u_dut100 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code),
        .tap_en_o(en100), .busy_o(busy100));

    wiper_ref #(.NUM_TAPS(256), .OVERLAP_CYC(1)) u_ref256 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code),
        .exp_en_o(x256), .exp_busy_o(xb256));

    wiper_ref #(.NUM_TAPS(100), .OVERLAP_CYC(3)) u_ref100 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code),
        .exp_en_o(x100), .exp_busy_o(xb100));

    function automatic logic [255:0] bitv(input int i);
        logic [255:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic [7:0] c);
        load = l;
        code = c;
        @(negedge clk);
    endtask

    // Per-cycle comparison of both instances against the model (R2 R3 R7) and R4.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(en256 == x256 && busy256 == xb256, "R2/R3 R7 taps256",
                {en256, 1'b0} >> 1, x256);
            chk(en100 == x100 && busy100 == xb100, "R2/R3 R7 taps100",
                256'(en100), 256'(x100));
            chk($countones(en256) inside {1, 2} && $countones(en100) inside {1, 2},
                "R4 taps never open", 256'($countones(en256)), 256'd1);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: state during reset.
        chk(en256 == bitv(0) && !busy256, "R1 in reset", en256, bitv(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(en256 == bitv(0) && !busy256, "R1 after reset 256", en256, bitv(0));
        chk(en100 == 100'd1 && !busy100, "R1 after reset 100", 256'(en100), bitv(0));
        cmp_on = 1;

        // R3 and R6: load code 15, overlap then tap 15.
        drive(1'b1, 8'd15);
        chk(en256 == (bitv(0) | bitv(15)) && busy256, "R3 overlap", en256, bitv(0) | bitv(15));
        drive(1'b0, 8'd0);
        chk(en256 == bitv(15) && !busy256, "R6 code maps to tap", en256, bitv(15));
        repeat (6) drive(1'b0, 8'd0);
        chk(en100 == 100'(bitv(15)) && !busy100, "R6 code maps to tap 100", 256'(en100), bitv(15));

        // R8: same tap reload.
        drive(1'b1, 8'd15);
        chk(en256 == bitv(15) && !busy256, "R8 same tap no overlap", en256, bitv(15));

        // R10: code ignored without load.
        repeat (3) drive(1'b0, 8'd200);
        chk(en256 == bitv(15) && !busy256 && en100 == 100'(bitv(15)), "R10 code ignored",
            en256, bitv(15));

        // R5 and R7: saturation and a wide jump.
        drive(1'b1, 8'd255);
        chk(en256 == (bitv(15) | bitv(255)), "R7 jump 15 to 255", en256, bitv(15) | bitv(255));
        repeat (6) drive(1'b0, 8'd0);
        chk(en256 == bitv(255), "R5 top code 256", en256, bitv(255));
        chk(en100 == 100'(bitv(99)) && !busy100, "R5 saturate 100", 256'(en100), bitv(99));

        // R9: loads during overlap on the 100-tap instance.
        drive(1'b1, 8'd10);
        drive(1'b1, 8'd20);
        drive(1'b1, 8'd30);
        drive(1'b0, 8'd0);
        chk(en100 == 100'(bitv(10)) && !busy100, "R9 overlap ends at first load",
            256'(en100), bitv(10));
        drive(1'b0, 8'd0);
        chk(en100 == 100'(bitv(10) | bitv(30)) && busy100, "R9 latest held load applied",
            256'(en100), bitv(10) | bitv(30));
        repeat (6) drive(1'b0, 8'd0);
        chk(en100 == 100'(bitv(30)), "R9 settles on held tap", 256'(en100), bitv(30));

        // R7: random loads across all codes.
        for (int i = 0; i < 2000; i++) begin
            drive(($urandom % 3) == 0, 8'($urandom % 256));
        end
        repeat (6) drive(1'b0, 8'd0);
        chk(!busy256 && !busy100, "R2 idle after random", 256'({busy256, busy100}), 256'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule